// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Timer

This block is the timing core of a processor supervisor. It counts ticks of a slow oscillator enable. From that count it holds the processor in reset while the supply is bad, and keeps it there for a fixed stretch once the supply recovers. It also watches a toggling watchdog input and pulses reset when the software stops servicing it. The supply-valid flag comes from an already synchronised comparator. The watchdog input is asynchronous and is synchronised inside the block. A separate disable flag stands for the floating or mid-level input state.

The watchdog uses an adaptive timeout. After any reset the long period is always in force. The short period takes over only when two things are true: the period select asks for it, and the watchdog input has toggled at least once since reset was released. A status output goes low on every watchdog timeout and returns high on the next input edge.

All periods are tick-count parameters. The defaults suit a 10.24 kHz enable:

| Period | Time | Ticks |
|---|---|---|
| Short reset pulse | 50 ms | 512 |
| Long reset pulse | 200 ms | 2048 |
| Short watchdog period | 100 ms | 1024 |
| Long watchdog period | 1.6 s | 16384 |

Top module: `supervisor_top`

## Requirements
- R1: While `supply_ok` is low, reset is asserted (`rst_out_n` = 0) from the next clock onward.
- R2: With `long_pulse` = 0, reset is released after exactly PULSE_SHORT ticks with `supply_ok` high. It is still asserted after PULSE_SHORT-1 ticks.
- R3: With `long_pulse` = 1, reset is released after exactly PULSE_LONG ticks. This applies both after a supply recovery and after a watchdog timeout.
- R4: `rst_out` is always the complement of `rst_out_n`.
- R5: After any reset is released, the watchdog times out after WD_LONG ticks without an input edge, even when `short_sel` = 1.
- R6: Once an input edge has been seen after reset release, the timeout is WD_SHORT ticks if `short_sel` = 1 and WD_LONG ticks if `short_sel` = 0.
- R7: Every edge of the synchronised watchdog input, rising or falling, restarts the watchdog count from zero.
- R8: A timeout asserts reset for the configured pulse width. The watchdog then restarts, so a constant input produces a reset pulse after every long period.
- R9: `wd_status` goes low on a timeout and stays low until the next input edge, which sets it high. It is forced high while `supply_ok` is low.
- R10: While `wd_off` = 1, no watchdog timeout occurs and the count is held at zero. When the watchdog is re-enabled, it counts a full period from zero.
- R11: A supply drop during the reset stretch restarts the stretch, so a full pulse width follows the return of the supply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset of the block's flops |
| tick_en | input | 1 | One-clock enable from the slow oscillator |
| supply_ok | input | 1 | Synchronised supply-valid flag |
| wd_in | input | 1 | Asynchronous watchdog input from software |
| wd_off | input | 1 | Watchdog disabled (input floating or mid-level) |
| short_sel | input | 1 | 1 requests the short watchdog period |
| long_pulse | input | 1 | 1 selects the long reset pulse |
| rst_out_n | output | 1 | Active-low processor reset |
| rst_out | output | 1 | Active-high processor reset |
| wd_status | output | 1 | Watchdog status, low after a timeout |

## Verification
Both reset outputs change on the same clock edge as the tick that completes a period, or as the clock that first samples `supply_ok` low. `wd_status` changes on that edge too, or two clocks after a watchdog input change because of the synchroniser. The bench separates ticks by four idle clocks and leaves four idle clocks after each input toggle, so every edge has settled before the next tick. All outputs are sampled on falling edges after a counted number of ticks, with the expected count taken directly from the tick parameters. Each period is probed at one tick short of its end and again at its end.

// File: rtl/supv_pkg.sv
package supv_pkg;
   typedef enum logic {
      WD_PER_LONG  = 1'b0,
      WD_PER_SHORT = 1'b1
   } wd_per_e;

   // bits needed to hold the values 0 .. n-1
   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic toggled
);
   logic [STAGES-1:0] chain;
   logic              prev;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= chain[STAGES-1];
   end

   assign toggled = chain[STAGES-1] ^ prev;
endmodule

// File: rtl/supv_stretch.sv
module supv_stretch
   import supv_pkg::*;
#(
   parameter int unsigned PULSE_SHORT = 512,
   parameter int unsigned PULSE_LONG  = 2048
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic supply_ok,
   input  logic trip,
   input  logic long_pulse,
   output logic active
);
   localparam int unsigned PMAX = (PULSE_LONG > PULSE_SHORT) ? PULSE_LONG : PULSE_SHORT;
   localparam int unsigned CW   = cnt_bits(PMAX);
   localparam logic [CW-1:0] LAST_S = CW'(PULSE_SHORT - 1);
   localparam logic [CW-1:0] LAST_L = CW'(PULSE_LONG - 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] last;

   assign last = long_pulse ? LAST_L : LAST_S;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b1;
         cnt    <= '0;
      end else if (!supply_ok || trip) begin
         active <= 1'b1;
         cnt    <= '0;
      end else if (active && tick_en) begin
         if (cnt >= last) begin
            active <= 1'b0;
            cnt    <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/supv_wdog.sv
module supv_wdog
   import supv_pkg::*;
#(
   parameter int unsigned WD_SHORT = 1024,
   parameter int unsigned WD_LONG  = 16384
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic supply_ok,
   input  logic hold,
   input  logic in_edge,
   input  logic wd_off,
   input  logic short_sel,
   output logic trip,
   output logic status
);
   localparam int unsigned CW = cnt_bits(WD_LONG);
   localparam logic [CW-1:0] LIM_S = CW'(WD_SHORT - 1);
   localparam logic [CW-1:0] LIM_L = CW'(WD_LONG - 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;
   logic          armed;
   wd_per_e       per;

   assign per  = (armed && short_sel) ? WD_PER_SHORT : WD_PER_LONG;
   assign lim  = (per == WD_PER_SHORT) ? LIM_S : LIM_L;
   assign trip = tick_en && !hold && !wd_off && !in_edge && (cnt >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         armed <= 1'b0;
      end else if (hold) begin
         cnt   <= '0;
         armed <= 1'b0;
      end else if (wd_off) begin
         cnt <= '0;
      end else if (in_edge) begin
         cnt   <= '0;
         armed <= 1'b1;
      end else if (trip) begin
         cnt <= '0;
      end else if (tick_en) begin
         cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         status <= 1'b1;
      else if (!supply_ok) status <= 1'b1;
      else if (in_edge)   status <= 1'b1;
      else if (trip)      status <= 1'b0;
   end
endmodule

// File: rtl/supervisor_top.sv
module supervisor_top
   import supv_pkg::*;
#(
   parameter int unsigned PULSE_SHORT = 512,
   parameter int unsigned PULSE_LONG  = 2048,
   parameter int unsigned WD_SHORT    = 1024,
   parameter int unsigned WD_LONG     = 16384,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic supply_ok,
   input  logic wd_in,
   input  logic wd_off,
   input  logic short_sel,
   input  logic long_pulse,
   output logic rst_out_n,
   output logic rst_out,
   output logic wd_status
);
   if (PULSE_SHORT < 1 || PULSE_LONG < 1) begin : g_bad_pulse
      $error("reset pulse widths must be at least one tick");
   end
   if (WD_SHORT < 1 || WD_SHORT > WD_LONG) begin : g_bad_wd
      $error("watchdog periods need 1 <= WD_SHORT <= WD_LONG");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic in_edge;
   logic trip;
   logic active;

   supv_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d       (wd_in),
      .toggled (in_edge)
   );

   supv_wdog #(.WD_SHORT(WD_SHORT), .WD_LONG(WD_LONG)) u_wdog (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .supply_ok (supply_ok),
      .hold      (active),
      .in_edge   (in_edge),
      .wd_off    (wd_off),
      .short_sel (short_sel),
      .trip      (trip),
      .status    (wd_status)
   );

   supv_stretch #(.PULSE_SHORT(PULSE_SHORT), .PULSE_LONG(PULSE_LONG)) u_stretch (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_en    (tick_en),
      .supply_ok  (supply_ok),
      .trip       (trip),
      .long_pulse (long_pulse),
      .active     (active)
   );

   assign rst_out_n = ~active;
   assign rst_out   = active;
endmodule

// File: rtl/supv_checker.sv
module supv_checker (
   input logic clk,
   input logic rst_n,
   input logic tick_en,
   input logic supply_ok,
   input logic wd_off,
   input logic rst_out_n,
   input logic rst_out,
   input logic wd_status
);
   assert_bad_supply_resets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> !rst_out_n);

   assert_release_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_out_n) |-> ($past(tick_en) && $past(supply_ok)));

   assert_complement_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rst_out == !rst_out_n);

   assert_status_fall_with_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wd_status) |-> $rose(rst_out));

   assert_status_high_bad_supply_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> wd_status);

   assert_disabled_no_trip_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wd_off) && $past(supply_ok) && $past(rst_out_n)) |-> rst_out_n);
endmodule

bind supervisor_top supv_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_en   (tick_en),
   .supply_ok (supply_ok),
   .wd_off    (wd_off),
   .rst_out_n (rst_out_n),
   .rst_out   (rst_out),
   .wd_status (wd_status)
);

// File: tb/sim_supervisor_top.sv
module sim_supervisor_top;
   localparam int PS = 4;
   localparam int PL = 8;
   localparam int WS = 6;
   localparam int WL = 12;

   logic clk = 1'b0;
   logic rst_n, tick_en, supply_ok, wd_in, wd_off, short_sel, long_pulse;
   logic rst_out_n, rst_out, wd_status;
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   always #10 clk = ~clk;

   supervisor_top #(
      .PULSE_SHORT(PS), .PULSE_LONG(PL), .WD_SHORT(WS), .WD_LONG(WL), .SYNC_STAGES(2)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .supply_ok(supply_ok),
      .wd_in(wd_in), .wd_off(wd_off), .short_sel(short_sel), .long_pulse(long_pulse),
      .rst_out_n(rst_out_n), .rst_out(rst_out), .wd_status(wd_status)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick_en = 1'b1;
         @(negedge clk) tick_en = 1'b0;
         repeat (3) @(negedge clk);
      end
   endtask

   task automatic toggle();
      @(negedge clk) wd_in = ~wd_in;
      repeat (4) @(negedge clk);
   endtask

   task automatic expect_rst(input bit asserted, input string req);
      chk(rst_out_n == !asserted, req, int'(rst_out_n), int'(!asserted));
      chk(rst_out == asserted, "R4", int'(rst_out), int'(asserted));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 0; tick_en = 0; supply_ok = 0; wd_in = 0; wd_off = 0;
      short_sel = 1; long_pulse = 0;
      repeat (4) @(negedge clk);
      rst_n = 1;
      repeat (2) @(negedge clk);
      expect_rst(1, "R1");
      chk(wd_status == 1, "R9", int'(wd_status), 1);

      // R2: short pulse after supply returns
      supply_ok = 1;
      ticks(PS - 1); expect_rst(1, "R2");
      ticks(1);      expect_rst(0, "R2");

      // R5: long period right after reset even with short selected
      ticks(WL - 1); expect_rst(0, "R5");
      ticks(1);      expect_rst(1, "R8");
      chk(wd_status == 0, "R9", int'(wd_status), 0);
      ticks(PS - 1); expect_rst(1, "R8");
      ticks(1);      expect_rst(0, "R8");

      // R8: constant input repeats after each long period
      ticks(WL - 1); expect_rst(0, "R8");
      ticks(1);      expect_rst(1, "R8");
      ticks(PS);     expect_rst(0, "R8");

      // R6: first edge arms the short period
      toggle();
      chk(wd_status == 1, "R9", int'(wd_status), 1);
      ticks(WS - 1); expect_rst(0, "R6");
      ticks(1);      expect_rst(1, "R6");
      ticks(PS);     expect_rst(0, "R2");

      // R7: falling then rising edge each restart the count
      toggle();
      ticks(WS - 2);
      toggle();
      ticks(WS - 1); expect_rst(0, "R7");
      ticks(1);      expect_rst(1, "R7");
      ticks(PS);     expect_rst(0, "R2");

      // R6: short_sel low keeps the long period after an edge
      short_sel = 0;
      toggle();
      ticks(WS);          expect_rst(0, "R6");
      ticks(WL - WS - 1); expect_rst(0, "R6");
      ticks(1);           expect_rst(1, "R6");
      chk(wd_status == 0, "R9", int'(wd_status), 0);

      // R1/R9: supply loss forces reset and status high
      supply_ok = 0;
      repeat (3) @(negedge clk);
      expect_rst(1, "R1");
      chk(wd_status == 1, "R9", int'(wd_status), 1);

      // R11: drop mid-stretch restarts the stretch
      supply_ok = 1;
      ticks(PS - 2);
      supply_ok = 0;
      repeat (2) @(negedge clk);
      supply_ok = 1;
      ticks(PS - 1); expect_rst(1, "R11");
      ticks(1);      expect_rst(0, "R11");

      // R10: disabled watchdog never trips, restarts from zero
      wd_off = 1;
      ticks(3 * WL); expect_rst(0, "R10");
      wd_off = 0;
      ticks(WL - 1); expect_rst(0, "R10");
      ticks(1);      expect_rst(1, "R10");
      ticks(PS);     expect_rst(0, "R2");

      // R3: long pulse after supply loss and after a timeout
      long_pulse = 1;
      supply_ok = 0;
      repeat (2) @(negedge clk);
      supply_ok = 1;
      ticks(PL - 1); expect_rst(1, "R3");
      ticks(1);      expect_rst(0, "R3");
      ticks(WL);     expect_rst(1, "R8");
      ticks(PL - 1); expect_rst(1, "R3");
      ticks(1);      expect_rst(0, "R3");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule